// File: doc/BRIEF.md
# Cache Array Maintenance Port

This block gives software a memory-mapped path into the tag and data storage of a 4-way set-associative cache with 16-byte lines. Both arrays live inside the block as register arrays. A request selects one of the two arrays, an entry (set), and either a way or associative mode. The tag side has three operations: a direct read, a direct write, and an associative write. The associative write compares a supplied tag against every way of one entry and rewrites only the valid and dirty flags of the way that hits. The data side gives longword reads and writes by entry, way and word index.

Invalidating a dirty line starts a write-back. The four longwords of the line go out on a memory write port with a valid/ready handshake. The address of each beat is built from the stored tag, the entry index and a word offset that steps 0x0, 0x4, 0x8, 0xC. Requests arrive on a valid/ready port. While a write-back is in flight, `req_ready` stays low, so no request is taken. Reads answer on `rsp_valid`/`rsp_rdata` exactly one cycle after acceptance, and this path has no back-pressure. The memory port holds its address and data steady for as long as `mem_ready` is low.

Top module: `cmp_array_port`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_valid` and `rsp_valid` are 0, and every way of every entry reads back tag 0 with its valid and dirty flags at 0.
- R2: Request address layout:
  - bit 24 selects the data array (1) or the tag array (0);
  - bit 3 is the associative bit for tag-array writes;
  - bits 10:4 give the entry;
  - bits 13:12 give the way;
  - bits 3:2 give the word for data accesses.
  
  Tag-array words carry the tag in bits 31:11, the dirty flag (U) in bit 1 and the valid flag (V) in bit 0. All other bits read as 0.
- R3: A direct tag-array write (bit 3 = 0) stores the tag, V and U into the addressed way. A tag-array read returns that word on `rsp_rdata`, with `rsp_valid` high, in the cycle after acceptance.
- R4: A data-array write stores one longword at entry/way/word. A data-array read returns it one cycle after acceptance. Data-array accesses never change any tag, V or U value.
- R5: A data-array access whose address bits 1:0 are not 00 is accepted and has no effect: nothing is stored and `rsp_valid` stays 0.
- R6: An associative write looks for ways of the entry whose V=1 and whose stored tag equals the supplied tag. In the way that hits, it writes only V and U. The stored tag is left unchanged, and so are the other ways.
- R7: An associative write with no hitting way changes nothing and starts no write-back.
- R8: Whenever V=0 is written to a way, by direct or associative write, its U becomes 0 whatever the U bit of the request.
- R9: When several ways hit, only the lowest-numbered one is updated.
- R10: An associative hit on a way whose stored U is 1 writes that line back as four beats in order. Each beat's address is {stored tag, entry, word, 2'b00}, for words 0,1,2,3, and its data is that way's stored word.
- R11: From the cycle after a dirty hit is accepted, `mem_valid` is high and `req_ready` is low. Each beat's address and data hold while `mem_ready` is low. `req_ready` returns in the cycle after the fourth beat's handshake.
- R12: An associative hit on a way whose stored U is 0 starts no write-back, even when the request sets U=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted (idle) |
| req_addr | input | 32 | Request address (array, entry, way, word, mode) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data or tag-array word |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| mem_valid | output | 1 | Write-back beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Write-back beat address |
| mem_wdata | output | 32 | Write-back beat data |

## Verification
Timing is counted from the clock edge at which a request is accepted:
- Tag and data state change at that same edge.
- A read answer is registered at that edge and is due in the cycle after it.
- For a dirty hit, the first beat appears in the cycle after it.

The bench drives inputs on falling edges and holds a request until the falling edge after its accepting rising edge. It samples the response at that falling edge and the memory port at every following falling edge. It stalls individual beats with `mem_ready` low and checks at each stalled sample that address and data have not moved. Effects on the tag array are observed by reading tag words back through the request port.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  // Request address bit positions that software relies on.
  localparam int SEL_BIT   = 24;
  localparam int ASSOC_BIT = 3;
  localparam int WAY_LSB   = 12;

  typedef struct packed {
    logic data_sel;
    logic assoc;
    logic aligned;
  } req_mode_t;
endpackage

// File: rtl/cmp_req_decode.sv
module cmp_req_decode
  import cmp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7,
  parameter int WAY_W  = 2,
  parameter int WORD_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output req_mode_t         mode,
  output logic [IDX_W-1:0]  idx,
  output logic [WAY_W-1:0]  way,
  output logic [WORD_W-1:0] word
);
  localparam int IDX_LSB = WORD_W + 2;

  assign mode.data_sel = addr[SEL_BIT];
  assign mode.assoc    = addr[ASSOC_BIT];
  assign mode.aligned  = (addr[1:0] == 2'b00);
  assign idx           = addr[IDX_LSB +: IDX_W];
  assign way           = addr[WAY_LSB +: WAY_W];
  assign word          = addr[2 +: WORD_W];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[ADDR_W-1:SEL_BIT+1],
                              addr[SEL_BIT-1:WAY_LSB+WAY_W],
                              addr[WAY_LSB-1:IDX_LSB+IDX_W]};
endmodule

// File: rtl/cmp_way_match.sv
module cmp_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 21,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [WAYS-1:0]       valid,
  input  logic [TAG_W-1:0]      cmp_tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g*TAG_W +: TAG_W] == cmp_tag);
  end

  // Lowest-numbered matching way wins.
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/cmp_wb_seq.sv
module cmp_wb_seq #(
  parameter int WORDS = 4,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mem_ready,
  output logic              busy,
  output logic [WORD_W-1:0] beat
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      beat <= '0;
    end else if (start) begin
      busy <= 1'b1;
      beat <= '0;
    end else if (busy && mem_ready) begin
      if (beat == WORD_W'(WORDS - 1)) busy <= 1'b0;
      else                            beat <= beat + 1'b1;
    end
  end
endmodule

// File: rtl/cmp_array_port.sv
module cmp_array_port
  import cmp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 21,
  parameter int ENTRIES = 128,
  parameter int WAYS    = 4,
  parameter int WORDS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int WORD_W  = $clog2(WORDS);
  localparam int PAD_W   = DATA_W - TAG_W - 2;
  localparam int LINES_W = IDX_W + WAY_W + WORD_W;
  localparam int NWORDS  = ENTRIES * WAYS * WORDS;

  // Storage
  logic [TAG_W-1:0]  tag_q  [ENTRIES][WAYS];
  logic [WAYS-1:0]   v_q    [ENTRIES];
  logic [WAYS-1:0]   u_q    [ENTRIES];
  logic [DATA_W-1:0] data_q [NWORDS];

  // Decode
  req_mode_t         d_mode;
  logic [IDX_W-1:0]  d_idx;
  logic [WAY_W-1:0]  d_way;
  logic [WORD_W-1:0] d_word;

  cmp_req_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAY_W(WAY_W), .WORD_W(WORD_W)
  ) u_decode (
    .addr(req_addr), .mode(d_mode), .idx(d_idx), .way(d_way), .word(d_word)
  );

  logic             busy;
  logic             acc;
  logic [TAG_W-1:0] w_tag;
  logic             w_v;
  logic             w_u;

  assign req_ready = !busy;
  assign acc       = req_valid && req_ready;
  assign w_tag     = req_wdata[DATA_W-1 -: TAG_W];
  assign w_v       = req_wdata[0];
  assign w_u       = req_wdata[1] && req_wdata[0];

  // Parallel tag compare over the selected entry
  logic [WAYS*TAG_W-1:0] ent_tags;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way;

  for (genvar g = 0; g < WAYS; g++) begin : g_ent
    assign ent_tags[g*TAG_W +: TAG_W] = tag_q[d_idx][g];
  end

  cmp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags(ent_tags), .valid(v_q[d_idx]), .cmp_tag(w_tag),
    .hit(hit), .hit_way(hit_way)
  );

  logic aa_write, aa_direct_wr, aa_assoc_wr, dat_write, wb_start;
  assign aa_write     = acc && req_write && !d_mode.data_sel;
  assign aa_direct_wr = aa_write && !d_mode.assoc;
  assign aa_assoc_wr  = aa_write && d_mode.assoc && hit;
  assign dat_write    = acc && req_write && d_mode.data_sel && d_mode.aligned;
  assign wb_start     = aa_assoc_wr && u_q[d_idx][hit_way];

  // Tag array and flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        v_q[e] <= '0;
        u_q[e] <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[e][w] <= '0;
      end
    end else if (aa_direct_wr) begin
      tag_q[d_idx][d_way] <= w_tag;
      v_q[d_idx][d_way]   <= w_v;
      u_q[d_idx][d_way]   <= w_u;
    end else if (aa_assoc_wr) begin
      v_q[d_idx][hit_way] <= w_v;
      u_q[d_idx][hit_way] <= w_u;
    end
  end

  // Data array
  logic [LINES_W-1:0] d_ptr;
  assign d_ptr = {d_idx, d_way, d_word};

  always_ff @(posedge clk) begin
    if (dat_write) data_q[d_ptr] <= req_wdata;
  end

  // Read response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc && !req_write && (!d_mode.data_sel || d_mode.aligned);
      if (acc && !req_write) begin
        if (d_mode.data_sel) rsp_rdata <= data_q[d_ptr];
        else rsp_rdata <= {tag_q[d_idx][d_way], {PAD_W{1'b0}},
                           u_q[d_idx][d_way], v_q[d_idx][d_way]};
      end
    end
  end

  // Write-back
  logic [TAG_W-1:0]  wb_tag;
  logic [IDX_W-1:0]  wb_idx;
  logic [WAY_W-1:0]  wb_way;
  logic [WORD_W-1:0] wb_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_tag <= '0;
      wb_idx <= '0;
      wb_way <= '0;
    end else if (wb_start) begin
      wb_tag <= tag_q[d_idx][hit_way];
      wb_idx <= d_idx;
      wb_way <= hit_way;
    end
  end

  cmp_wb_seq #(.WORDS(WORDS)) u_wb (
    .clk(clk), .rst_n(rst_n), .start(wb_start), .mem_ready(mem_ready),
    .busy(busy), .beat(wb_beat)
  );

  assign mem_valid = busy;
  assign mem_addr  = {wb_tag, wb_idx, wb_beat, 2'b00};
  assign mem_wdata = data_q[{wb_idx, wb_way, wb_beat}];
endmodule

// File: rtl/cmp_array_port_chk.sv
module cmp_array_port_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata)); // R11
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready); // R11
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && (mem_addr[3:2] != 2'b11)
    |=> mem_valid && (mem_addr[3:2] == $past(mem_addr[3:2]) + 2'b01)); // R10
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> mem_addr[3:0] == 4'h0); // R10
  AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00); // R10
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write)); // R3
endmodule

bind cmp_array_port cmp_array_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/test_cmp_array_port.sv
module test_cmp_array_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic        rsp_v_s;
  logic [31:0] rsp_d_s;
  logic [31:0] exp_w [4];
  int          stall [4];

  always #4 clk = ~clk;

  cmp_array_port i_cmp_array_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] aaddr(int idx, int way, bit assoc);
    return (32'(way) << 12) | (32'(idx) << 4) | (32'(assoc) << 3);
  endfunction
  function automatic logic [31:0] daddr(int idx, int way, int word);
    return (32'd1 << 24) | (32'(way) << 12) | (32'(idx) << 4) | (32'(word) << 2);
  endfunction
  function automatic logic [31:0] tword(logic [20:0] tag, bit u, bit v);
    return {tag, 9'b0, u, v};
  endfunction

  task automatic do_req(logic [31:0] a, bit we, logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = we; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_v_s = rsp_valid;
    rsp_d_s = rsp_rdata;
  endtask

  task automatic chk_tag(string rq, int idx, int way, logic [31:0] exp);
    do_req(aaddr(idx, way, 0), 0, '0);
    chk({rq, " rsp_valid"}, 32'(rsp_v_s), 32'd1);
    chk({rq, " tag word"}, rsp_d_s, exp);
  endtask

  task automatic chk_data(string rq, int idx, int way, int word, logic [31:0] exp);
    do_req(daddr(idx, way, word), 0, '0);
    chk({rq, " rsp_valid"}, 32'(rsp_v_s), 32'd1);
    chk({rq, " data"}, rsp_d_s, exp);
  endtask

  // Called at the falling edge right after a dirty hit was accepted.
  task automatic drain(string rq, logic [31:0] base);
    chk({rq, " busy blocks request"}, 32'(req_ready), 32'd0);
    for (int k = 0; k < 4; k++) begin
      mem_ready = 1'b0;
      for (int s = 0; s < stall[k]; s++) begin
        chk({rq, " stalled valid"}, 32'(mem_valid), 32'd1);
        chk({rq, " stalled addr"}, mem_addr, base + 32'(4 * k));
        chk({rq, " stalled data"}, mem_wdata, exp_w[k]);
        @(negedge clk);
      end
      mem_ready = 1'b1;
      chk({rq, " beat valid"}, 32'(mem_valid), 32'd1);
      chk({rq, " beat addr"}, mem_addr, base + 32'(4 * k));
      chk({rq, " beat data"}, mem_wdata, exp_w[k]);
      @(negedge clk);
    end
    mem_ready = 1'b0;
    chk("R11 done valid low", 32'(mem_valid), 32'd0);
    chk("R11 ready back", 32'(req_ready), 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 mem_valid", 32'(mem_valid), 32'd0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk_tag("R1 reset flags", 5, 2, 32'd0);
    chk_tag("R1 reset flags", 127, 3, 32'd0);
  endtask

  task automatic t_direct_tag;
    do_req(aaddr(5, 2, 0), 1, tword(21'h1ABCDE, 1, 1));
    chk("R3 no rsp on write", 32'(rsp_v_s), 32'd0);
    chk_tag("R3 direct write", 5, 2, tword(21'h1ABCDE, 1, 1));
    chk_tag("R2 other way untouched", 5, 1, 32'd0);
    do_req(aaddr(6, 0, 0), 1, tword(21'h00777, 1, 0));
    chk_tag("R8 direct V0 clears U", 6, 0, tword(21'h00777, 0, 0));
  endtask

  task automatic t_data;
    do_req(daddr(5, 2, 0), 1, 32'hDEAD0000);
    do_req(daddr(5, 2, 3), 1, 32'hDEAD0003);
    do_req(daddr(5, 1, 0), 1, 32'hBEEF0100);
    chk_data("R4 read w0", 5, 2, 0, 32'hDEAD0000);
    chk_data("R4 read w3", 5, 2, 3, 32'hDEAD0003);
    chk_data("R4 other way", 5, 1, 0, 32'hBEEF0100);
    chk_tag("R4 tags untouched", 5, 2, tword(21'h1ABCDE, 1, 1));
  endtask

  task automatic t_misaligned;
    do_req(daddr(5, 2, 0) | 32'd1, 1, 32'h12345678);
    chk_data("R5 misaligned write ignored", 5, 2, 0, 32'hDEAD0000);
    do_req(daddr(5, 2, 0) | 32'd2, 0, '0);
    chk("R5 misaligned read no rsp", 32'(rsp_v_s), 32'd0);
  endtask

  task automatic t_miss;
    for (int w = 0; w < 4; w++) do_req(aaddr(7, w, 0), 1, tword(21'(32'h100 + w), 1, 1));
    do_req(aaddr(7, 0, 1), 1, tword(21'h0ABCD, 0, 0));
    chk("R7 miss no write-back", 32'(mem_valid), 32'd0);
    for (int w = 0; w < 4; w++) chk_tag("R7 miss unchanged", 7, w, tword(21'(32'h100 + w), 1, 1));
  endtask

  task automatic t_clean_hit;
    for (int w = 0; w < 4; w++) do_req(aaddr(8, w, 0), 1, tword(21'(32'h200 + w), 0, 1));
    do_req(aaddr(8, 0, 1), 1, tword(21'h202, 1, 0));
    chk("R12 clean hit no write-back", 32'(mem_valid), 32'd0);
    chk_tag("R8 assoc V0 clears U", 8, 2, tword(21'h202, 0, 0));
    chk_tag("R6 neighbour way kept", 8, 1, tword(21'h201, 0, 1));
    do_req(aaddr(8, 3, 1), 1, tword(21'h203, 1, 1));
    chk("R12 U set no write-back", 32'(mem_valid), 32'd0);
    chk_tag("R6 flags only", 8, 3, tword(21'h203, 1, 1));
    do_req(aaddr(8, 0, 1), 1, tword(21'h202, 1, 1));
    chk_tag("R6 invalid way never hits", 8, 2, tword(21'h202, 0, 0));
  endtask

  task automatic t_multi_hit;
    do_req(aaddr(9, 1, 0), 1, tword(21'h0F00D, 0, 1));
    do_req(aaddr(9, 3, 0), 1, tword(21'h0F00D, 0, 1));
    do_req(aaddr(9, 0, 1), 1, tword(21'h0F00D, 0, 0));
    chk_tag("R9 lowest way updated", 9, 1, tword(21'h0F00D, 0, 0));
    chk_tag("R9 higher way kept", 9, 3, tword(21'h0F00D, 0, 1));
  endtask

  task automatic t_dirty_wb(string rq, int idx, int way, logic [20:0] tag, bit nv,
                            int s0, int s1, int s2, int s3);
    do_req(aaddr(idx, way, 0), 1, tword(tag, 1, 1));
    for (int k = 0; k < 4; k++) begin
      exp_w[k] = {8'hA5, 8'(idx), 8'(way), 8'(k)};
      do_req(daddr(idx, way, k), 1, exp_w[k]);
    end
    stall[0] = s0; stall[1] = s1; stall[2] = s2; stall[3] = s3;
    do_req(aaddr(idx, 0, 1), 1, tword(tag, 1, nv));
    drain(rq, {tag, 7'(idx), 4'h0});
    chk_tag("R10 flags after write-back", idx, way, tword(tag, nv, nv));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct_tag();
    t_data();
    t_misaligned();
    t_miss();
    t_clean_hit();
    t_multi_hit();
    t_dirty_wb("R10 invalidate dirty", 51, 1, 21'h0F0F0, 0, 0, 2, 0, 1);
    t_dirty_wb("R11 keep valid dirty", 127, 3, 21'h1FFFF, 1, 0, 0, 3, 0);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule